// File: doc/BRIEF.md
# DMA Channel Flow Control Unit

This block paces one DMA channel as it walks a chain of linked descriptor entries. It watches the peripheral's request lines and grants them one at a time. For each granted request it issues one transfer strobe per beat. It sends a one-cycle clear back to the requesting line when the last beat of that request goes out. When an entry is finished, it raises a terminal-count pulse and then either asks the descriptor fetcher for the next entry or shuts the channel down.

Each entry selects one of two ways to mark its end. In controller-counted mode, the entry carries a beat count, and the block ends the entry when that many beats have moved. In this mode the two "last" request lines have no effect. In peripheral-terminated mode, the count is not used. The entry runs until a request that arrived on a "last" line has been fully served. The bus data path and the descriptor reads belong to neighbouring logic. The fetcher hands over each entry through a load request and acknowledge pair.

Top module: `dma_flow_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, chan_en, chan_done, load_req, beat_vld, tc_pulse, brst_clr and sngl_clr are all 0.
- R2: A start pulse while idle raises chan_en and load_req on the next cycle and clears chan_done. The entry is taken in on the cycle load_ack is high. While load_req is high, no beat_vld and no clear is issued, whatever the request lines do.
- R3: In controller-counted mode (ld_pflow = 0), an entry ends after exactly ld_cnt beats. A burst grant moves min(BURST_LEN, beats still owed) beats. An entry loaded with ld_cnt = 0 ends with no beats.
- R4: In controller-counted mode, either brst_req or sngl_req starts a transfer. A single request moves exactly one beat.
- R5: In controller-counted mode, last_brst_req and last_sngl_req cause no beats and no clears.
- R6: When the burst and single requests are both active in the arbitration cycle, the burst request is served first.
- R7: A served request gets a one-cycle clear in the same cycle as its final beat. brst_clr answers a burst grant and sngl_clr answers a single grant. The beats of one request run on back-to-back cycles, and beat_vld is low in the cycle after a clear.
- R8: In peripheral-terminated mode (ld_pflow = 1), ld_cnt is ignored. A burst always moves BURST_LEN beats. last_brst_req acts as a burst request and last_sngl_req as a single request. The entry ends only after a request on one of those last lines has been served.
- R9: tc_pulse is high for exactly one cycle, in the cycle right after the final beat of every entry (or right after the load of an empty controller-counted entry).
- R10: In the cycle after tc_pulse, a nonzero ld_next of the finished entry raises load_req. A zero ld_next instead drops chan_en and raises chan_done, which stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; begins a descriptor chain when idle |
| load_ack | input | 1 | Fetcher presents a new entry this cycle |
| ld_cnt | input | CNT_W | Beat count of the entry (controller-counted mode) |
| ld_pflow | input | 1 | Entry mode: 1 peripheral-terminated, 0 controller-counted |
| ld_next | input | PTR_W | Next-entry pointer of the entry; zero ends the chain |
| brst_req | input | 1 | Burst request from the peripheral |
| sngl_req | input | 1 | Single request from the peripheral |
| last_brst_req | input | 1 | Final burst request of an entry |
| last_sngl_req | input | 1 | Final single request of an entry |
| load_req | output | 1 | Asks the fetcher for the next entry |
| beat_vld | output | 1 | Transfer strobe, one per beat |
| brst_clr | output | 1 | Clear for a served burst request |
| sngl_clr | output | 1 | Clear for a served single request |
| tc_pulse | output | 1 | Terminal count, one cycle per finished entry |
| chan_en | output | 1 | Channel enabled |
| chan_done | output | 1 | Chain finished with a zero next pointer |

## Verification
On every cycle, the assertions check the following. The owed-beat counter steps down by one per beat in controller-counted mode and never beats from zero. That counter stays untouched in peripheral-terminated mode. Beats inside a request are back-to-back. Clears never fall inside a load. The terminal-count pulse is one cycle wide, and chan_done rises only right after that pulse with the channel disabled. Other properties need whole request sequences, and only the bench scenarios can show them. These include the clipping of the final burst, burst-over-single priority, the silence of the last lines in controller-counted mode, and the ignored count in peripheral-terminated mode. They also include the exact beat totals of randomly sized chains.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOAD,
      S_ARB,
      S_BEAT,
      S_ENDE
   } dfc_state_e;

   typedef struct packed {
      logic vld;
      logic brst;
      logic last;
   } dfc_grant_t;

endpackage

// File: rtl/dfc_req_arb.sv
module dfc_req_arb
   import dfc_pkg::*;
(
   input  logic       en,
   input  logic       pflow,
   input  logic       brst_req,
   input  logic       sngl_req,
   input  logic       last_brst_req,
   input  logic       last_sngl_req,
   output dfc_grant_t grant
);

   logic want_b;
   logic want_s;

   always_comb begin
      // last lines only count as requests when the peripheral ends the entry
      want_b     = brst_req | (pflow & last_brst_req);
      want_s     = sngl_req | (pflow & last_sngl_req);
      grant.vld  = en & (want_b | want_s);
      grant.brst = want_b;
      grant.last = pflow & (want_b ? last_brst_req : last_sngl_req);
   end

endmodule

// File: rtl/dfc_beat_cnt.sv
module dfc_beat_cnt #(
   parameter int BURST_LEN = 4,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             brst,
   input  logic             clip_en,
   input  logic [CNT_W-1:0] rem,
   input  logic             beat,
   output logic             last
);

   generate
      if (BURST_LEN > 1) begin : g_cnt
         localparam int BW = $clog2(BURST_LEN + 1);
         localparam logic [CNT_W-1:0] BLEN = CNT_W'(BURST_LEN);

         logic [BW-1:0]    left_q;
         logic [CNT_W-1:0] want;

         always_comb begin
            if (!brst)
               want = CNT_W'(1);
            else if (clip_en && (rem < BLEN))
               want = rem;
            else
               want = BLEN;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (load)
               left_q <= BW'(want);
            else if (beat && (left_q != '0))
               left_q <= left_q - 1'b1;
         end

         assign last = (left_q == BW'(1));

         // R7
         burst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (beat && !last) |=> beat);
      end else begin : g_one
         logic unused_in;
         assign unused_in = ^{load, brst, clip_en, rem, beat, clk, rst_n};
         assign last      = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
   import dfc_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             load_ack,
   input  logic [CNT_W-1:0] ld_cnt,
   input  logic             ld_pflow,
   input  logic [PTR_W-1:0] ld_next,
   input  dfc_grant_t       grant,
   input  logic             bc_last,
   output logic             arb_en,
   output logic             bc_load,
   output logic             pflow,
   output logic [CNT_W-1:0] rem,
   output logic             load_req,
   output logic             beat,
   output logic             brst_clr,
   output logic             sngl_clr,
   output logic             tc_pulse,
   output logic             chan_en,
   output logic             chan_done
);

   dfc_state_e       st_q, st_d;
   logic [CNT_W-1:0] rem_q;
   logic             pflow_q;
   logic             more_q;
   logic             kind_brst_q;
   logic             last_flag_q;
   logic             chan_en_q;
   logic             chan_done_q;
   logic             ent_end;

   always_comb begin
      st_d    = st_q;
      ent_end = pflow_q ? last_flag_q : (rem_q == CNT_W'(1));
      unique case (st_q)
         S_IDLE: if (start) st_d = S_LOAD;
         S_LOAD: if (load_ack) st_d = (!ld_pflow && (ld_cnt == '0)) ? S_ENDE : S_ARB;
         S_ARB:  if (grant.vld) st_d = S_BEAT;
         S_BEAT: if (bc_last) st_d = ent_end ? S_ENDE : S_ARB;
         S_ENDE: st_d = more_q ? S_LOAD : S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         rem_q       <= '0;
         pflow_q     <= 1'b0;
         more_q      <= 1'b0;
         kind_brst_q <= 1'b0;
         last_flag_q <= 1'b0;
         chan_en_q   <= 1'b0;
         chan_done_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == S_IDLE && start) begin
            chan_en_q   <= 1'b1;
            chan_done_q <= 1'b0;
         end
         if (st_q == S_LOAD && load_ack) begin
            rem_q   <= ld_cnt;
            pflow_q <= ld_pflow;
            more_q  <= (ld_next != '0);
         end
         if (st_q == S_ARB && grant.vld) begin
            kind_brst_q <= grant.brst;
            last_flag_q <= grant.last;
         end
         if (st_q == S_BEAT && !pflow_q)
            rem_q <= rem_q - CNT_W'(1);
         if (st_q == S_ENDE) begin
            chan_en_q   <= more_q;
            chan_done_q <= !more_q;
         end
      end
   end

   assign arb_en    = (st_q == S_ARB);
   assign bc_load   = arb_en && grant.vld;
   assign pflow     = pflow_q;
   assign rem       = rem_q;
   assign load_req  = (st_q == S_LOAD);
   assign beat      = (st_q == S_BEAT);
   assign brst_clr  = beat && bc_last && kind_brst_q;
   assign sngl_clr  = beat && bc_last && !kind_brst_q;
   assign tc_pulse  = (st_q == S_ENDE);
   assign chan_en   = chan_en_q;
   assign chan_done = chan_done_q;

   // R3
   rem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !pflow_q) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

   // R3
   rem_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !pflow_q) |-> (rem_q != '0));

   // R8
   pflow_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && pflow_q) |=> $stable(rem_q));

   // R2
   load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> !(brst_clr || sngl_clr));

   // R7
   clr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brst_clr || sngl_clr) |=> !beat);

   // R9
   tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |=> !tc_pulse);

   // R10
   done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_done) |-> (!chan_en && $past(tc_pulse)));

endmodule

// File: rtl/dma_flow_ctl.sv
module dma_flow_ctl
   import dfc_pkg::*;
#(
   parameter int BURST_LEN = 4,
   parameter int CNT_W     = 8,
   parameter int PTR_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             load_ack,
   input  logic [CNT_W-1:0] ld_cnt,
   input  logic             ld_pflow,
   input  logic [PTR_W-1:0] ld_next,
   input  logic             brst_req,
   input  logic             sngl_req,
   input  logic             last_brst_req,
   input  logic             last_sngl_req,
   output logic             load_req,
   output logic             beat_vld,
   output logic             brst_clr,
   output logic             sngl_clr,
   output logic             tc_pulse,
   output logic             chan_en,
   output logic             chan_done
);

   generate
      if (CNT_W < 1 || PTR_W < 1) begin : g_bad_w
         $error("dma_flow_ctl: CNT_W and PTR_W must be at least 1");
      end
      if (BURST_LEN < 1 || BURST_LEN >= (1 << CNT_W)) begin : g_bad_bl
         $error("dma_flow_ctl: BURST_LEN must lie in 1 .. 2**CNT_W-1");
      end
   endgenerate

   dfc_grant_t       grant;
   logic             arb_en;
   logic             bc_load;
   logic             bc_last;
   logic             pflow;
   logic [CNT_W-1:0] rem;

   dfc_req_arb u_arb (
      .en            (arb_en),
      .pflow         (pflow),
      .brst_req      (brst_req),
      .sngl_req      (sngl_req),
      .last_brst_req (last_brst_req),
      .last_sngl_req (last_sngl_req),
      .grant         (grant)
   );

   dfc_beat_cnt #(
      .BURST_LEN (BURST_LEN),
      .CNT_W     (CNT_W)
   ) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (bc_load),
      .brst    (grant.brst),
      .clip_en (!pflow),
      .rem     (rem),
      .beat    (beat_vld),
      .last    (bc_last)
   );

   dfc_seq #(
      .CNT_W (CNT_W),
      .PTR_W (PTR_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .load_ack  (load_ack),
      .ld_cnt    (ld_cnt),
      .ld_pflow  (ld_pflow),
      .ld_next   (ld_next),
      .grant     (grant),
      .bc_last   (bc_last),
      .arb_en    (arb_en),
      .bc_load   (bc_load),
      .pflow     (pflow),
      .rem       (rem),
      .load_req  (load_req),
      .beat      (beat_vld),
      .brst_clr  (brst_clr),
      .sngl_clr  (sngl_clr),
      .tc_pulse  (tc_pulse),
      .chan_en   (chan_en),
      .chan_done (chan_done)
   );

   // R6
   brst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && brst_req && sngl_req) |=> (beat_vld && !$past(load_req)) );

endmodule

// File: tb/test_dma_flow_ctl.sv
module test_dma_flow_ctl;

   localparam int BL    = 4;
   localparam int CNT_W = 8;
   localparam int PTR_W = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start;
   logic             load_ack;
   logic [CNT_W-1:0] ld_cnt;
   logic             ld_pflow;
   logic [PTR_W-1:0] ld_next;
   logic             brst_req, sngl_req, last_brst_req, last_sngl_req;
   logic             load_req, beat_vld, brst_clr, sngl_clr, tc_pulse, chan_en, chan_done;

   int total = 0;
   int bad   = 0;
   int tc_cnt = 0;
   int hold_bad = 0;
   bit finished = 0;

   int d_cnt [8];
   bit d_pf  [8];
   int d_nx  [8];
   int ld_idx = 0;
   int ld_dly = 0;

   always #5 clk = ~clk;

   dma_flow_ctl #(.BURST_LEN(BL), .CNT_W(CNT_W), .PTR_W(PTR_W)) i_dma_flow_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .load_ack(load_ack),
      .ld_cnt(ld_cnt), .ld_pflow(ld_pflow), .ld_next(ld_next),
      .brst_req(brst_req), .sngl_req(sngl_req),
      .last_brst_req(last_brst_req), .last_sngl_req(last_sngl_req),
      .load_req(load_req), .beat_vld(beat_vld), .brst_clr(brst_clr),
      .sngl_clr(sngl_clr), .tc_pulse(tc_pulse), .chan_en(chan_en),
      .chan_done(chan_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_beats(input bit brst, input bit clip, input int remain);
      if (!brst) return 1;
      if (clip && remain < BL) return remain;
      return BL;
   endfunction

   // descriptor fetcher model
   initial begin
      load_ack = 0; ld_cnt = '0; ld_pflow = 0; ld_next = '0;
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1 && load_req && !load_ack) begin
            repeat (ld_dly) @(negedge clk);
            ld_cnt   = CNT_W'(d_cnt[ld_idx]);
            ld_pflow = d_pf[ld_idx];
            ld_next  = PTR_W'(d_nx[ld_idx]);
            load_ack = 1;
            ld_idx++;
            @(negedge clk);
            load_ack = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (tc_pulse) tc_cnt++;
         if (load_req && (beat_vld || brst_clr || sngl_clr)) hold_bad++;
      end
   end

   task automatic wait_clr(output int beats, output bit bc, output bit sc);
      beats = 0; bc = 0; sc = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (beat_vld) beats++;
         if (brst_clr || sngl_clr) begin
            bc = brst_clr; sc = sngl_clr;
            break;
         end
      end
   endtask

   task automatic req_do(input bit brst, input bit last, output int beats, output bit bc, output bit sc);
      if (brst) begin if (last) last_brst_req = 1; else brst_req = 1; end
      else      begin if (last) last_sngl_req = 1; else sngl_req = 1; end
      wait_clr(beats, bc, sc);
      brst_req = 0; sngl_req = 0; last_brst_req = 0; last_sngl_req = 0;
   endtask

   task automatic do_start();
      start = 1;
      @(negedge clk);
      start = 0;
   endtask

   task automatic serve(input bit brst, input bit last, input int exp, input string tag);
      int b; bit bc, sc;
      req_do(brst, last, b, bc, sc);
      chk(b == exp, tag, b, exp);
      chk(brst ? (bc && !sc) : (sc && !bc), "R7", {bc, sc}, brst ? 2 : 1);
   endtask

   task automatic expect_tc(input string tag);
      @(negedge clk);
      chk(tc_pulse == 1, tag, tc_pulse, 1);
   endtask

   task automatic expect_done();
      @(negedge clk);
      chk(chan_done == 1 && chan_en == 0, "R10", {chan_done, chan_en}, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int b, t0, nreq;
      bit bc, sc;
      void'($urandom(32'd4242));
      rst_n = 0; start = 0;
      brst_req = 0; sngl_req = 0; last_brst_req = 0; last_sngl_req = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({chan_en, chan_done, load_req, beat_vld, tc_pulse, brst_clr, sngl_clr} == 0, "R1", 1, 0);
      rst_n = 1;
      @(negedge clk);
      chk({chan_en, chan_done, load_req, beat_vld, tc_pulse, brst_clr, sngl_clr} == 0, "R1", 1, 0);

      // controller-counted chain: 10 then 3 beats, slow loads
      d_cnt[0] = 10; d_pf[0] = 0; d_nx[0] = 5;
      d_cnt[1] = 3;  d_pf[1] = 0; d_nx[1] = 0;
      ld_idx = 0; ld_dly = 3;
      do_start();
      chk(chan_en && load_req, "R2", {chan_en, load_req}, 3);
      serve(1, 0, 4, "R3");
      serve(1, 0, 4, "R3");
      serve(1, 0, 2, "R3");
      expect_tc("R9");
      @(negedge clk);
      chk(load_req == 1, "R10", load_req, 1);
      serve(0, 0, 1, "R4");
      serve(1, 0, 2, "R3");
      expect_tc("R9");
      expect_done();
      repeat (4) @(negedge clk);
      chk(chan_done == 1, "R10", chan_done, 1);

      // last lines ignored in controller-counted mode
      d_cnt[0] = 2; d_pf[0] = 0; d_nx[0] = 0;
      ld_idx = 0; ld_dly = 0;
      do_start();
      chk(chan_done == 0, "R2", chan_done, 0);
      last_brst_req = 1; last_sngl_req = 1;
      b = 0; sc = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (beat_vld) b++;
         if (brst_clr || sngl_clr) sc = 1;
      end
      last_brst_req = 0; last_sngl_req = 0;
      chk(b == 0 && !sc, "R5", b, 0);
      serve(0, 0, 1, "R4");
      serve(0, 0, 1, "R4");
      expect_tc("R9");
      expect_done();

      // burst before single
      d_cnt[0] = 5; d_pf[0] = 0; d_nx[0] = 0;
      ld_idx = 0; ld_dly = 1;
      do_start();
      brst_req = 1; sngl_req = 1;
      wait_clr(b, bc, sc);
      brst_req = 0;
      chk(b == BL && bc && !sc, "R6", b, BL);
      wait_clr(b, bc, sc);
      sngl_req = 0;
      chk(b == 1 && sc && !bc, "R6", b, 1);
      expect_tc("R9");
      expect_done();

      // peripheral-terminated chain, count field nonzero and ignored
      d_cnt[0] = 1; d_pf[0] = 1; d_nx[0] = 9;
      d_cnt[1] = 0; d_pf[1] = 1; d_nx[1] = 0;
      ld_idx = 0; ld_dly = 2;
      do_start();
      t0 = tc_cnt;
      serve(1, 0, BL, "R8");
      serve(0, 0, 1, "R8");
      serve(1, 0, BL, "R8");
      @(negedge clk);
      chk(tc_cnt == t0, "R8", tc_cnt, t0);
      serve(0, 1, 1, "R8");
      expect_tc("R9");
      serve(1, 1, BL, "R8");
      expect_tc("R9");
      expect_done();

      // empty controller-counted entry
      d_cnt[0] = 0; d_pf[0] = 0; d_nx[0] = 0;
      ld_idx = 0; ld_dly = 0;
      t0 = tc_cnt;
      do_start();
      b = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (beat_vld) b++;
      end
      chk(b == 0 && tc_cnt == t0 + 1, "R3", b, 0);
      chk(chan_done == 1, "R10", chan_done, 1);

      // random chains, mixed modes
      for (int ch = 0; ch < 12; ch++) begin
         int nent;
         nent = 1 + int'($urandom % 3);
         for (int e = 0; e < nent; e++) begin
            d_pf[e]  = bit'($urandom % 2);
            d_cnt[e] = d_pf[e] ? int'($urandom % 4) : 1 + int'($urandom % 14);
            d_nx[e]  = (e == nent - 1) ? 0 : 16 + e;
         end
         ld_idx = 0; ld_dly = int'($urandom % 4);
         do_start();
         for (int e = 0; e < nent; e++) begin
            if (!d_pf[e]) begin
               int remain;
               remain = d_cnt[e];
               while (remain > 0) begin
                  bit kb;
                  int x;
                  kb = bit'($urandom % 2);
                  x  = exp_beats(kb, 1, remain);
                  serve(kb, 0, x, "R3");
                  remain -= x;
               end
            end else begin
               nreq = 1 + int'($urandom % 3);
               for (int r = 0; r < nreq; r++) begin
                  bit kb;
                  kb = bit'($urandom % 2);
                  serve(kb, r == nreq - 1, exp_beats(kb, 0, 0), "R8");
               end
            end
            expect_tc("R9");
         end
         expect_done();
      end

      chk(hold_bad == 0, "R2", hold_bad, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule